// File: doc/BRIEF.md
# Exception Special-Register File

This block keeps the six 32-bit special registers that a pipelined core needs for exception handling: the live interrupt mask, the saved mask, the latched cause vector, the two saved program counters (current and delayed) and one word of handler data. Software reaches them through one combinational read port and one clocked write port. These ports serve the move-from-special and move-to-special instructions.

On interrupt entry (`jisr`), several registers change in the same clock edge. The cause vector is latched and the mask is cleared. The saved PCs and the saved mask are taken from either the pre-instruction or the post-instruction values, depending on the interrupt kind. The handler data word is also written, and the PC-load outputs steer the fetch unit to a fixed handler address. A return-from-exception (`rfe`) copies the saved mask back into the live mask and presents the saved PCs on the same PC-load outputs. The ports are sideband control signals sampled every cycle, so there is no valid/ready handshake and no back-pressure.

Top module: `exc_sreg_file`

## Requirements
- R1: While `rst_n` is low and after it is released, all six registers read zero and `pc_load` is 0 while neither `jisr` nor `rfe` is high.
- R2: Register addresses are: live mask 0, saved mask 1, cause 2, saved PC 3, saved delayed PC 4, data 5. A move write with `mv_wr_en`=1 stores `mv_wr_data` at `mv_wr_addr` at the clock edge. `mv_rd_data` shows the entry at `mv_rd_addr` combinationally.
- R3: On `jisr`, the cause register loads `cause_masked`.
- R4: `int_kind` encodes 0 repeat, 1 continue, 2 abort. On `jisr` with repeat, the saved PC, saved delayed PC and saved mask take `pc_now`, `dpc_now` and the live mask register. With continue, they take `pc_after`, `dpc_after` and `sr_after`.
- R5: On `jisr` with abort, the saved PC, saved delayed PC and saved mask keep their values.
- R6: On `jisr`, the live mask (`sr_mask`) becomes zero at the next edge.
- R7: On `jisr`, the data register loads the sign-extended 16-bit `trap_imm` when `cause_masked` bit 5 (trap) is set. Otherwise it loads `eff_addr`.
- R8: While `jisr` is high, `pc_load`=1, `pc_load_val`=`HANDLER_PC` and `dpc_load_val`=`HANDLER_PC`+4 in the same cycle.
- R9: While `rfe` is high and `jisr` is low, `pc_load`=1 and the load values equal the saved PC and saved delayed PC. At the edge, the live mask takes the saved mask.
- R10: `jisr` has priority over `rfe` and over a move write in the same cycle. Both of those are discarded.
- R11: `rfe` has priority over a move write in the same cycle. The move is discarded.
- R12: A read of an address above 5 returns zero, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mv_wr_en | input | 1 | Move-to-special write strobe |
| mv_wr_addr | input | 3 | Write address |
| mv_wr_data | input | 32 | Write data |
| mv_rd_addr | input | 3 | Read address |
| mv_rd_data | output | 32 | Read data (combinational) |
| jisr | input | 1 | Interrupt entry |
| int_kind | input | 2 | 0 repeat, 1 continue, 2 abort |
| cause_masked | input | 32 | Masked cause vector |
| pc_now | input | 32 | PC of interrupted instruction |
| dpc_now | input | 32 | Delayed PC of interrupted instruction |
| pc_after | input | 32 | PC following the instruction |
| dpc_after | input | 32 | Delayed PC following the instruction |
| sr_after | input | 32 | Mask value after the instruction |
| trap_imm | input | 16 | Trap immediate |
| eff_addr | input | 32 | Load/store effective address |
| rfe | input | 1 | Return from exception |
| sr_mask | output | 32 | Live interrupt mask |
| pc_load | output | 1 | Force a new PC this cycle |
| pc_load_val | output | 32 | PC to load |
| dpc_load_val | output | 32 | Delayed PC to load |

## Verification
A wrong interrupt-kind selection stays hidden until an `rfe` or a move read brings out the saved PC or mask. The bench therefore reads every saved register one cycle after each entry. A stale or un-cleared live mask is visible on `sr_mask` at the first edge after `jisr` or `rfe`. A wrong priority among `jisr`, `rfe` and move writes leaves the move's data in a register. That shows on the read port on the next cycle.

// File: rtl/exc_sreg_pkg.sv
package exc_sreg_pkg;
  typedef enum logic [1:0] {
    KIND_REPEAT = 2'd0,
    KIND_CONT   = 2'd1,
    KIND_ABORT  = 2'd2
  } int_kind_e;

  localparam int IDX_SR    = 0;
  localparam int IDX_ESR   = 1;
  localparam int IDX_ECA   = 2;
  localparam int IDX_EPC   = 3;
  localparam int IDX_EDPC  = 4;
  localparam int IDX_EDATA = 5;
  localparam int TRAP_BIT  = 5;
endpackage

// File: rtl/exc_save_calc.sv
module exc_save_calc #(
  parameter int DW   = 32,
  parameter int IMMW = 16
) (
  input  logic [1:0]    kind,
  input  logic [DW-1:0] sr_q,
  input  logic [DW-1:0] sr_after,
  input  logic [DW-1:0] pc_now,
  input  logic [DW-1:0] dpc_now,
  input  logic [DW-1:0] pc_after,
  input  logic [DW-1:0] dpc_after,
  input  logic [DW-1:0] cause,
  input  logic [IMMW-1:0] trap_imm,
  input  logic [DW-1:0] eff_addr,
  output logic          save_en,
  output logic [DW-1:0] esr_v,
  output logic [DW-1:0] epc_v,
  output logic [DW-1:0] edpc_v,
  output logic [DW-1:0] edata_v
);
  import exc_sreg_pkg::*;

  localparam int EXTW = DW - IMMW;

  int_kind_e k;
  logic      is_repeat;

  always_comb begin
    k         = int_kind_e'(kind);
    is_repeat = (k == KIND_REPEAT);
    save_en   = (k == KIND_REPEAT) || (k == KIND_CONT);
    esr_v     = is_repeat ? sr_q    : sr_after;
    epc_v     = is_repeat ? pc_now  : pc_after;
    edpc_v    = is_repeat ? dpc_now : dpc_after;
    edata_v   = cause[TRAP_BIT] ? {{EXTW{trap_imm[IMMW-1]}}, trap_imm} : eff_addr;
  end
endmodule

// File: rtl/sreg_rd_mux.sv
module sreg_rd_mux #(
  parameter int DW   = 32,
  parameter int NREG = 6,
  parameter int AW   = 3
) (
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [AW-1:0]           addr,
  output logic [DW-1:0]           data
);
  logic [NREG-1:0][DW-1:0] term;

  for (genvar i = 0; i < NREG; i++) begin : g_term
    assign term[i] = (addr == AW'(i)) ? regs[i] : '0;
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < NREG; i++) data = data | term[i];
  end
endmodule

// File: rtl/exc_sreg_file.sv
module exc_sreg_file #(
  parameter int          DW         = 32,
  parameter int          IMMW       = 16,
  parameter int          AW         = 3,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mv_wr_en,
  input  logic [AW-1:0] mv_wr_addr,
  input  logic [DW-1:0] mv_wr_data,
  input  logic [AW-1:0] mv_rd_addr,
  output logic [DW-1:0] mv_rd_data,
  input  logic          jisr,
  input  logic [1:0]    int_kind,
  input  logic [DW-1:0] cause_masked,
  input  logic [DW-1:0] pc_now,
  input  logic [DW-1:0] dpc_now,
  input  logic [DW-1:0] pc_after,
  input  logic [DW-1:0] dpc_after,
  input  logic [DW-1:0] sr_after,
  input  logic [IMMW-1:0] trap_imm,
  input  logic [DW-1:0] eff_addr,
  input  logic          rfe,
  output logic [DW-1:0] sr_mask,
  output logic          pc_load,
  output logic [DW-1:0] pc_load_val,
  output logic [DW-1:0] dpc_load_val
);
  import exc_sreg_pkg::*;

  localparam int NREG = 6;
  localparam logic [DW-1:0] H_PC  = DW'(HANDLER_PC);
  localparam logic [DW-1:0] H_DPC = DW'(HANDLER_PC) + DW'(4);

  logic [NREG-1:0][DW-1:0] regs_q, regs_d;
  logic [NREG-1:0]         wr_hit;
  logic                    save_en;
  logic [DW-1:0]           esr_v, epc_v, edpc_v, edata_v;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = mv_wr_en && (mv_wr_addr == AW'(i));
  end

  exc_save_calc #(.DW(DW), .IMMW(IMMW)) u_save (
    .kind      (int_kind),
    .sr_q      (regs_q[IDX_SR]),
    .sr_after  (sr_after),
    .pc_now    (pc_now),
    .dpc_now   (dpc_now),
    .pc_after  (pc_after),
    .dpc_after (dpc_after),
    .cause     (cause_masked),
    .trap_imm  (trap_imm),
    .eff_addr  (eff_addr),
    .save_en   (save_en),
    .esr_v     (esr_v),
    .epc_v     (epc_v),
    .edpc_v    (edpc_v),
    .edata_v   (edata_v)
  );

  always_comb begin
    regs_d = regs_q;
    if (jisr) begin
      regs_d[IDX_SR]    = '0;
      regs_d[IDX_ECA]   = cause_masked;
      regs_d[IDX_EDATA] = edata_v;
      if (save_en) begin
        regs_d[IDX_ESR]  = esr_v;
        regs_d[IDX_EPC]  = epc_v;
        regs_d[IDX_EDPC] = edpc_v;
      end
    end else if (rfe) begin
      regs_d[IDX_SR] = regs_q[IDX_ESR];
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_hit[i]) regs_d[i] = mv_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  sreg_rd_mux #(.DW(DW), .NREG(NREG), .AW(AW)) u_rd (
    .regs (regs_q),
    .addr (mv_rd_addr),
    .data (mv_rd_data)
  );

  always_comb begin
    sr_mask      = regs_q[IDX_SR];
    pc_load      = jisr || rfe;
    pc_load_val  = jisr ? H_PC  : regs_q[IDX_EPC];
    dpc_load_val = jisr ? H_DPC : regs_q[IDX_EDPC];
  end
endmodule

// File: rtl/exc_sreg_chk.sv
module exc_sreg_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          jisr,
  input logic          rfe,
  input logic [1:0]    int_kind,
  input logic [DW-1:0] cause_masked,
  input logic          mv_wr_en,
  input logic [AW-1:0] mv_wr_addr,
  input logic [AW-1:0] mv_rd_addr,
  input logic [DW-1:0] mv_rd_data,
  input logic [DW-1:0] sr_mask,
  input logic [DW-1:0] q_esr,
  input logic [DW-1:0] q_eca,
  input logic [DW-1:0] q_epc,
  input logic [DW-1:0] q_edpc
);
  p_cause_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    jisr |=> q_eca == $past(cause_masked));

  p_abort_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (jisr && int_kind == 2'd2) |=> ($stable(q_epc) && $stable(q_esr) && $stable(q_edpc)));

  p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jisr |=> sr_mask == '0);

  p_rfe_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !jisr) |=> sr_mask == $past(q_esr));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!jisr && !rfe && !(mv_wr_en && mv_wr_addr == '0)) |=> $stable(sr_mask));

  p_rd_hole_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_rd_addr > AW'(5)) |-> mv_rd_data == '0);
endmodule

bind exc_sreg_file exc_sreg_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .jisr         (jisr),
  .rfe          (rfe),
  .int_kind     (int_kind),
  .cause_masked (cause_masked),
  .mv_wr_en     (mv_wr_en),
  .mv_wr_addr   (mv_wr_addr),
  .mv_rd_addr   (mv_rd_addr),
  .mv_rd_data   (mv_rd_data),
  .sr_mask      (sr_mask),
  .q_esr        (regs_q[1]),
  .q_eca        (regs_q[2]),
  .q_epc        (regs_q[3]),
  .q_edpc       (regs_q[4])
);

// File: tb/exc_sreg_file_bench.sv
module exc_sreg_file_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mv_wr_en;
  logic [2:0]  mv_wr_addr;
  logic [31:0] mv_wr_data;
  logic [2:0]  mv_rd_addr;
  logic [31:0] mv_rd_data;
  logic        jisr;
  logic [1:0]  int_kind;
  logic [31:0] cause_masked, pc_now, dpc_now, pc_after, dpc_after, sr_after, eff_addr;
  logic [15:0] trap_imm;
  logic        rfe;
  logic [31:0] sr_mask, pc_load_val, dpc_load_val;
  logic        pc_load;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_sreg_file u_exc_sreg_file (
    .clk(clk), .rst_n(rst_n), .mv_wr_en(mv_wr_en), .mv_wr_addr(mv_wr_addr),
    .mv_wr_data(mv_wr_data), .mv_rd_addr(mv_rd_addr), .mv_rd_data(mv_rd_data),
    .jisr(jisr), .int_kind(int_kind), .cause_masked(cause_masked),
    .pc_now(pc_now), .dpc_now(dpc_now), .pc_after(pc_after), .dpc_after(dpc_after),
    .sr_after(sr_after), .trap_imm(trap_imm), .eff_addr(eff_addr), .rfe(rfe),
    .sr_mask(sr_mask), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .dpc_load_val(dpc_load_val)
  );

  localparam logic [34:0] VEC [8] = '{
    {3'd0, 32'h0000_00F0}, {3'd1, 32'h0000_0C0C}, {3'd2, 32'h0000_0001},
    {3'd3, 32'h0000_2000}, {3'd4, 32'h0000_2004}, {3'd5, 32'h5555_AAAA},
    {3'd6, 32'hFFFF_FFFF}, {3'd7, 32'h1234_5678}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    mv_rd_addr = a;
    #1;
    chk(req, mv_rd_data, exp);
  endtask

  task automatic idle();
    mv_wr_en = 0; jisr = 0; rfe = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; idle(); mv_wr_addr = 0; mv_wr_data = 0; mv_rd_addr = 0;
    int_kind = 0; cause_masked = 0; pc_now = 0; dpc_now = 0; pc_after = 0;
    dpc_after = 0; sr_after = 0; trap_imm = 0; eff_addr = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1: reset state
    for (int a = 0; a < 6; a++) rd_chk("R1 reset", 3'(a), 32'h0);
    chk("R1 pc_load idle", {31'h0, pc_load}, 32'h0);

    // R2 / R12: table of move writes, each read back next cycle
    for (int v = 0; v < 8; v++) begin
      mv_wr_en = 1; mv_wr_addr = VEC[v][34:32]; mv_wr_data = VEC[v][31:0];
      step();
      mv_wr_en = 0;
      rd_chk(VEC[v][34:32] > 3'd5 ? "R12 hole read" : "R2 move rw",
             VEC[v][34:32], VEC[v][34:32] > 3'd5 ? 32'h0 : VEC[v][31:0]);
    end
    // R12: the writes to 6 and 7 left all six entries intact
    for (int a = 0; a < 6; a++) rd_chk("R12 hole write", 3'(a), VEC[a][31:0]);

    // R9 + R11: rfe with a competing move to the mask and read of saved PC
    rfe = 1; mv_wr_en = 1; mv_wr_addr = 3'd0; mv_wr_data = 32'h0000_0077;
    #1;
    chk("R9 pc_load", {31'h0, pc_load}, 32'h1);
    chk("R9 pc val", pc_load_val, 32'h0000_2000);
    chk("R9 dpc val", dpc_load_val, 32'h0000_2004);
    step(); idle();
    chk("R9 R11 mask restored", sr_mask, 32'h0000_0C0C);

    // R4 repeat, R10 jisr beats rfe and move, R8 handler address, R7 eff addr
    mv_wr_en = 1; mv_wr_addr = 3'd0; mv_wr_data = 32'hA5A5_0F0F;
    step(); idle();
    jisr = 1; rfe = 1; int_kind = 2'd0; cause_masked = 32'h0000_0010;
    pc_now = 32'h3000; dpc_now = 32'h3004; pc_after = 32'h3004; dpc_after = 32'h3008;
    sr_after = 32'h1; eff_addr = 32'hCAFE_0000; trap_imm = 16'h0;
    mv_wr_en = 1; mv_wr_addr = 3'd3; mv_wr_data = 32'h0000_DEAD;
    #1;
    chk("R8 handler pc", pc_load_val, 32'h0000_0100);
    chk("R8 handler dpc", dpc_load_val, 32'h0000_0104);
    step(); idle();
    chk("R6 mask cleared", sr_mask, 32'h0);
    rd_chk("R3 cause", 3'd2, 32'h0000_0010);
    rd_chk("R4 R10 repeat epc", 3'd3, 32'h3000);
    rd_chk("R4 repeat edpc", 3'd4, 32'h3004);
    rd_chk("R4 repeat esr", 3'd1, 32'hA5A5_0F0F);
    rd_chk("R7 eff addr", 3'd5, 32'hCAFE_0000);

    // R4 continue, R7 trap immediate sign extension
    mv_wr_en = 1; mv_wr_addr = 3'd0; mv_wr_data = 32'h33;
    step(); idle();
    jisr = 1; int_kind = 2'd1; cause_masked = 32'h0000_0020; trap_imm = 16'h8001;
    pc_after = 32'h4008; dpc_after = 32'h400C; sr_after = 32'h77;
    step(); idle();
    rd_chk("R4 cont epc", 3'd3, 32'h4008);
    rd_chk("R4 cont edpc", 3'd4, 32'h400C);
    rd_chk("R4 cont esr", 3'd1, 32'h77);
    rd_chk("R7 trap sext", 3'd5, 32'hFFFF_8001);
    chk("R6 mask cleared cont", sr_mask, 32'h0);

    // R5 abort keeps saved state
    jisr = 1; int_kind = 2'd2; cause_masked = 32'h1; pc_now = 32'h9; dpc_now = 32'hD;
    sr_after = 32'hF; eff_addr = 32'h0BAD_0000;
    step(); idle();
    rd_chk("R5 abort epc", 3'd3, 32'h4008);
    rd_chk("R5 abort edpc", 3'd4, 32'h400C);
    rd_chk("R5 abort esr", 3'd1, 32'h77);
    rd_chk("R3 abort cause", 3'd2, 32'h1);
    rd_chk("R7 abort data", 3'd5, 32'h0BAD_0000);

    // R9: rfe now restores the continue-saved mask and PCs
    rfe = 1;
    #1;
    chk("R9 pc val 2", pc_load_val, 32'h4008);
    step(); idle();
    chk("R9 mask restored 2", sr_mask, 32'h77);
    #1;
    chk("R1 pc_load low", {31'h0, pc_load}, 32'h0);

    finish_run();
  end
endmodule